// File: doc/BRIEF.md
# Fractional-Rate Microsecond Timer

This block keeps a free-running microsecond count while it is clocked straight from a reference oscillator whose frequency depends on the board. A rational scale factor, held as a pair of eight-bit numbers, turns the reference rate into an exact average of one count per microsecond. The ratio need not be an integer: a 19.2 MHz reference gets 5 counts in every 96 reference cycles, spread evenly by a running remainder.

Software programs the ratio once at start-up. It then measures delays by reading the count twice and taking the signed difference, which stays correct when the counter wraps. The bus is a single-cycle port: an address, a write strobe with data, and a read strobe. Read data is registered.

Top module: `usec_timer`

## Requirements
- R1: While reset is high and on the first edge after it, the counter is 0, the scale register is 0 and the remainder accumulator is 0. Scale value 0 means one count per reference cycle.
- R2: A read at address 0x04 returns the scale register. Bits [7:0] hold the divisor minus one and bits [15:8] the dividend minus one. Bits [31:16] read as zero and drop written data. A read at any address other than 0x00 or 0x04 returns zero.
- R3: With dividend D+1 not above divisor V+1, the counter advances by exactly floor(M*(D+1)/(V+1)) over the M reference cycles that follow a scale write.
- R4: Scale value 0x045f (5/96) gives exactly 5 counts per 96 reference cycles. After a write, 19 cycles give 0 counts and 20 cycles give 1.
- R5: Scale values 0x000b, 0x000c and 0x0019 give one count every 12, 13 and 26 reference cycles. For 0x000b the first count comes on the 12th cycle after the write, not on the 11th.
- R6: When the dividend field exceeds the divisor field, the counter advances by one on every reference cycle.
- R7: The counter never advances by more than one in a reference cycle.
- R8: A scale write clears the accumulator and gives no count on its own edge. The counter keeps its value across the write.
- R9: Writes to address 0x00 change neither the counter nor the scale register.
- R10: A read strobe at address 0x00 returns, on the next cycle, the counter value held just before the sampling edge. Back-to-back reads under scale 0 differ by one. The read data holds its value while no read is strobed.
- R11: The counter wraps modulo 2^CNT_W. The modular difference of two readings M cycles apart under scale 0 equals M, even across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address of the register accessed |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe, sampled on the rising edge |
| rd_data | output | DATA_W | Registered read data, valid one cycle after the strobe |

## Verification
The assertions assume that every strobe and address is steady around each rising edge, and that reset is held for at least one edge before any access. They also assume a write and a read are never strobed in the same cycle, because a read in a write cycle would see the old scale value. The stimulus changes every input only on falling edges, strobes one access per cycle, and starts the narrow-counter wrap check only after the count has climbed near its top.

// File: rtl/usec_timer_pkg.sv
package usec_timer_pkg;

    localparam int FLD_W = 8;
    localparam int CFG_W = 2 * FLD_W;
    localparam int ACC_W = FLD_W + 1;

    localparam int CNT_OFF = 'h00;
    localparam int CFG_OFF = 'h04;

    typedef struct packed {
        logic [FLD_W-1:0] dvd_m1;
        logic [FLD_W-1:0] div_m1;
    } scale_cfg_t;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CNT,
        SEL_CFG
    } reg_sel_t;

    function automatic logic [ACC_W-1:0] plus_one(input logic [FLD_W-1:0] v);
        return {1'b0, v} + ACC_W'(1);
    endfunction

    function automatic logic over_unity(input scale_cfg_t c);
        return c.dvd_m1 > c.div_m1;
    endfunction

endpackage

// File: rtl/usec_bus_port.sv
module usec_bus_port
    import usec_timer_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [CFG_W-1:0]  wr_cfg,
    input  logic              rd_en,
    input  logic [CNT_W-1:0]  count_q,
    output scale_cfg_t        cfg_q,
    output logic              cfg_wr,
    output logic [DATA_W-1:0] rd_data
);

    reg_sel_t sel;

    always_comb begin
        if (addr == ADDR_W'(CNT_OFF))      sel = SEL_CNT;
        else if (addr == ADDR_W'(CFG_OFF)) sel = SEL_CFG;
        else                               sel = SEL_NONE;
    end

    assign cfg_wr = wr_en && (sel == SEL_CFG);

    always_ff @(posedge clk) begin
        if (rst)         cfg_q <= '0;
        else if (cfg_wr) cfg_q <= scale_cfg_t'(wr_cfg);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            case (sel)
                SEL_CNT: rd_data <= DATA_W'(count_q);
                SEL_CFG: rd_data <= DATA_W'(cfg_q);
                default: rd_data <= '0;
            endcase
        end
    end

endmodule

// File: rtl/usec_rate_acc.sv
module usec_rate_acc
    import usec_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  scale_cfg_t       cfg,
    input  logic             clr,
    output logic             tick,
    output logic [ACC_W-1:0] acc_q
);

    logic [ACC_W-1:0] inc;
    logic [ACC_W-1:0] thr;
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] acc_d;

    assign inc = plus_one(cfg.dvd_m1);
    assign thr = plus_one(cfg.div_m1);
    // acc_q < thr <= 256 and inc <= 256, so the sum fits ACC_W bits
    assign sum = acc_q + inc;

    always_comb begin
        tick  = 1'b0;
        acc_d = sum;
        if (clr) begin
            acc_d = '0;
        end else if (over_unity(cfg)) begin
            tick  = 1'b1;
            acc_d = '0;
        end else if (sum >= thr) begin
            tick  = 1'b1;
            acc_d = sum - thr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= acc_d;
    end

endmodule

// File: rtl/usec_count.sv
module usec_count #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    output logic [CNT_W-1:0] count_q
);

    always_ff @(posedge clk) begin
        if (rst)       count_q <= '0;
        else if (tick) count_q <= count_q + CNT_W'(1);
    end

endmodule

// File: rtl/usec_timer.sv
module usec_timer
    import usec_timer_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data
);

    scale_cfg_t       cfg_q;
    logic             cfg_wr;
    logic             tick;
    logic [ACC_W-1:0] acc_q;
    logic [CNT_W-1:0] count_q;

    logic unused_wr_hi;
    assign unused_wr_hi = &{1'b0, wr_data[DATA_W-1:CFG_W]};

    usec_bus_port #(
        .CNT_W (CNT_W),
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
    ) u_port (
        .clk    (clk),
        .rst    (rst),
        .addr   (addr),
        .wr_en  (wr_en),
        .wr_cfg (wr_data[CFG_W-1:0]),
        .rd_en  (rd_en),
        .count_q(count_q),
        .cfg_q  (cfg_q),
        .cfg_wr (cfg_wr),
        .rd_data(rd_data)
    );

    usec_rate_acc u_acc (
        .clk  (clk),
        .rst  (rst),
        .cfg  (cfg_q),
        .clr  (cfg_wr),
        .tick (tick),
        .acc_q(acc_q)
    );

    usec_count #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .count_q(count_q)
    );

endmodule

// File: rtl/usec_timer_chk.sv
module usec_timer_chk
    import usec_timer_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input scale_cfg_t        cfg_q,
    input logic              cfg_wr,
    input logic              tick,
    input logic [ACC_W-1:0]  acc_q,
    input logic [CNT_W-1:0]  count_q
);

    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (count_q == '0 && acc_q == '0 && cfg_q == '0));

    p_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == ADDR_W'(CFG_OFF)) |=> rd_data[DATA_W-1:CFG_W] == '0);

    p_acc_bound_r3: assert property (@(posedge clk) disable iff (rst)
        acc_q <= {1'b0, cfg_q.div_m1});

    p_clamp_r6: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.dvd_m1 > cfg_q.div_m1 && !cfg_wr) |-> tick);

    p_single_step_r7: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (count_q - $past(count_q)) <= CNT_W'(1));

    p_cfg_write_r8: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> (acc_q == '0 && count_q == $past(count_q)));

    p_ctr_write_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(CNT_OFF)) |=> cfg_q == $past(cfg_q));

    p_read_latency_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == ADDR_W'(CNT_OFF)) |=> rd_data == DATA_W'($past(count_q)));

    p_read_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

    p_count_step_r11: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> count_q == $past(count_q) + CNT_W'($past(tick)));

endmodule

bind usec_timer usec_timer_chk #(
    .CNT_W (CNT_W),
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .addr   (addr),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .rd_data(rd_data),
    .cfg_q  (cfg_q),
    .cfg_wr (cfg_wr),
    .tick   (tick),
    .acc_q  (acc_q),
    .count_q(count_q)
);

// File: tb/test_usec_timer.sv
module test_usec_timer;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_CNT = 8'h00;
    localparam logic [7:0] A_CFG = 8'h04;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;

    logic [7:0]  n_addr = '0;
    logic        n_wr_en = 1'b0;
    logic [31:0] n_wr_data = '0;
    logic        n_rd_en = 1'b0;
    logic [31:0] n_rd_data;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usec_timer i_usec_timer (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data)
    );

    usec_timer #(.CNT_W(8)) i_usec_timer_w8 (
        .clk(clk), .rst(rst), .addr(n_addr), .wr_en(n_wr_en),
        .wr_data(n_wr_data), .rd_en(n_rd_en), .rd_data(n_rd_data)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        d = rd_data;
        rd_en = 1'b0;
    endtask

    function automatic logic [31:0] exp_ticks(input logic [15:0] cfg, input int m);
        int dvd = int'(cfg[15:8]) + 1;
        int dv  = int'(cfg[7:0]) + 1;
        if (dvd > dv) return 32'(m);
        return 32'((m * dvd) / dv);
    endfunction

    // Write cfg, then count advance over M cycles after that write
    task automatic measure(input string tag, input logic [15:0] cfg, input int m);
        logic [31:0] c0, c1;
        bus_write(A_CFG, {16'h0, cfg});
        bus_read(A_CNT, c0);
        repeat (m - 1) @(negedge clk);
        bus_read(A_CNT, c1);
        check(tag, c1 - c0, exp_ticks(cfg, m));
    endtask

    task automatic t_reset();
        logic [31:0] v;
        bus_read(A_CNT, v);
        check("R1 counter after reset", v, 32'h0);
        bus_read(A_CFG, v);
        check("R1 scale after reset", v, 32'h0);
    endtask

    task automatic t_default_and_general();
        measure("R1 default one per cycle", 16'h0000, 37);
        measure("R3 ratio 3/5", 16'h0204, 50);
        measure("R3 ratio 1/256", 16'h00ff, 600);
    endtask

    task automatic t_integer();
        measure("R5 12MHz", 16'h000b, 120);
        measure("R5 13MHz", 16'h000c, 130);
        measure("R5 26MHz", 16'h0019, 260);
        measure("R5 12MHz 11 cycles", 16'h000b, 11);
        measure("R5 12MHz 12 cycles", 16'h000b, 12);
    endtask

    task automatic t_frac();
        measure("R4 19.2MHz 96", 16'h045f, 96);
        measure("R4 19.2MHz 960", 16'h045f, 960);
        measure("R4 19.2MHz 19", 16'h045f, 19);
        measure("R4 19.2MHz 20", 16'h045f, 20);
    endtask

    task automatic t_clamp();
        measure("R6 clamp 6/1", 16'h0500, 40);
        measure("R6 clamp 256/1", 16'hff00, 40);
        measure("R7 unity 256/256", 16'hffff, 40);
    endtask

    task automatic t_map();
        logic [31:0] v;
        bus_write(A_CFG, 32'hABCD_1234);
        bus_read(A_CFG, v);
        check("R2 upper bits dropped", v, 32'h0000_1234);
        bus_read(8'h08, v);
        check("R2 unmapped reads zero", v, 32'h0);
    endtask

    task automatic t_ctr_write();
        logic [31:0] c0, c1, v;
        bus_write(A_CFG, 32'h0);
        bus_read(A_CNT, c0);
        bus_write(A_CNT, 32'h0);
        bus_read(A_CNT, c1);
        check("R9 counter write ignored", c1 - c0, 32'd2);
        bus_read(A_CFG, v);
        check("R9 scale untouched", v, 32'h0);
    endtask

    task automatic t_cfg_keep();
        logic [31:0] c0, c1;
        bus_write(A_CFG, 32'h0);
        repeat (5) @(negedge clk);
        bus_read(A_CNT, c0);
        bus_write(A_CFG, 32'h000b);
        bus_read(A_CNT, c1);
        check("R8 counter kept, no tick on write", c1 - c0, 32'd1);
    endtask

    task automatic t_read();
        logic [31:0] a, b;
        bus_write(A_CFG, 32'h0);
        bus_read(A_CNT, a);
        bus_read(A_CNT, b);
        check("R10 back-to-back reads", b - a, 32'd1);
        repeat (3) @(negedge clk);
        check("R10 read data held", rd_data, b);
    endtask

    task automatic t_wrap();
        logic [31:0] r0, r1;
        int tries = 0;
        r0 = '0;
        n_addr = A_CNT;
        while (r0 < 32'd200 && tries < 400) begin
            n_rd_en = 1'b1;
            @(negedge clk);
            r0 = n_rd_data;
            n_rd_en = 1'b0;
            tries++;
        end
        repeat (99) @(negedge clk);
        n_rd_en = 1'b1;
        @(negedge clk);
        r1 = n_rd_data;
        n_rd_en = 1'b0;
        check("R11 wrapped value", r1, (r0 + 32'd100) & 32'hff);
        check("R11 modular difference", 32'((r1 - r0) & 32'hff), 32'd100);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_default_and_general();
        t_integer();
        t_frac();
        t_clamp();
        t_map();
        t_ctr_write();
        t_cfg_keep();
        t_read();
        t_wrap();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule